// File: doc/BRIEF.md
# Numeric Error Interrupt Handshake

This block sits on the chipset side of the legacy floating-point error path. The processor reports unmasked numeric errors on `num_err_i`. When native exception reporting is off, the block raises a level interrupt request. When it is on, the block emits a one-cycle internal exception pulse and leaves the interrupt request alone. The block also drives an error output that follows the error-summary bit of the floating-point status word, and it keeps an ignore-error flag. A software write to a fixed I/O port sets that flag and drops the interrupt request. The error output remains asserted until software loads a status word whose error-summary bit is clear. That load also clears the ignore flag.

The block holds the status word itself. A status-word load takes the stack-top pointer out of bits 13:11 and stores those bits as zero. It also forces the busy bit (15) to equal the error-summary bit (7). A push on the register stack decrements the stack-top pointer modulo 8. The interrupt request and the error output are separate signals, and each is released by a different event.

Top module: `fpe_err_handshake`

## Requirements
- R1: After reset, `irq_o`, `ferr_o`, `ignne_o` and `exc_o` are 0, `top_o` is 0 and `fsw_o` is 0.
- R2: A `num_err_i` cycle with `native_en_i`=0 and `ignne_o`=0 sets `irq_o` to 1 on the next cycle. The same cycle sets `fsw_o` bits 7 and 15 to 1, so `ferr_o` becomes 1.
- R3: A `num_err_i` cycle with `native_en_i`=1 makes `exc_o` 1 for exactly the next cycle and leaves `irq_o` unchanged.
- R4: An I/O write (`io_wr_i`=1) with `io_addr_i` equal to `ERR_PORT` (default 16'h00F0) sets `ignne_o` to 1 and clears `irq_o` on the next cycle. `ferr_o` is unchanged.
- R5: An I/O read of `ERR_PORT`, or an I/O write to any other address, changes none of `irq_o`, `ignne_o` or `ferr_o`.
- R6: While `ignne_o` is 1, a new `num_err_i` does not assert `irq_o`.
- R7: A status-word load (`sw_load_i`=1) with `sw_data_i[7]`=0 clears `ferr_o`, `ignne_o` and `irq_o` on the next cycle.
- R8: On a status-word load, `top_o` takes `sw_data_i[13:11]`, and `fsw_o[13:11]` is stored as 0. The other bits come from `sw_data_i`, except bit 15.
- R9: On a status-word load, `fsw_o[15]` is set equal to `sw_data_i[7]`, whatever the value of `sw_data_i[15]`.
- R10: A `push_i` cycle without a load decrements `top_o` by 1 modulo 8, so 0 becomes 7.
- R11: `irq_o` is a level output. Once set, it holds through idle cycles until a port write (R4) or an error-summary clear (R7).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| num_err_i | input | 1 | Unmasked numeric error event, one cycle per error |
| native_en_i | input | 1 | Native exception reporting enabled |
| io_wr_i | input | 1 | I/O write strobe |
| io_rd_i | input | 1 | I/O read strobe |
| io_addr_i | input | 16 | I/O port address |
| sw_load_i | input | 1 | Status-word load strobe |
| sw_data_i | input | 16 | Status word to load |
| push_i | input | 1 | Register-stack push |
| irq_o | output | 1 | Error interrupt request, level |
| ferr_o | output | 1 | Error output, follows the error-summary bit |
| ignne_o | output | 1 | Ignore-numeric-error flag |
| exc_o | output | 1 | Internal exception pulse, native mode |
| top_o | output | 3 | Stack-top pointer |
| fsw_o | output | 16 | Stored status word, bits 13:11 zero |

## Verification
The assertions assume that `num_err_i`, `sw_load_i`, `push_i` and the I/O strobes are sampled as clean single-cycle events. They also assume that a port write and an error-summary clear never arrive in the same cycle as a conflicting event, because the stability property on the interrupt excludes only the port-write and clear events it knows about. The directed stimulus drives one event per cycle, changes inputs only on the falling edge, and returns every strobe to 0 before the next scenario.

// File: rtl/fpe_pkg.sv
package fpe_pkg;
  localparam int unsigned SW_W    = 16;
  localparam int unsigned TOP_W   = 3;
  localparam int unsigned TOP_LSB = 11;
  localparam int unsigned ES_BIT  = 7;
  localparam int unsigned BUSY_BIT = 15;
  localparam logic [SW_W-1:0] TOP_MASK = ((SW_W)'((1 << TOP_W) - 1)) << TOP_LSB;
endpackage

// File: rtl/fpe_port_decode.sv
module fpe_port_decode #(
  parameter int unsigned ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] ERR_PORT = 'h00F0
) (
  input  logic              io_wr_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  output logic              port_hit_o
);
  // reads never decode
  assign port_hit_o = io_wr_i && (io_addr_i == ERR_PORT);
endmodule

// File: rtl/fpe_status_reg.sv
module fpe_status_reg
  import fpe_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             num_err_i,
  input  logic             sw_load_i,
  input  logic [SW_W-1:0]  sw_data_i,
  input  logic             push_i,
  output logic [SW_W-1:0]  fsw_o,
  output logic [TOP_W-1:0] top_o
);
  logic [SW_W-1:0]  fsw_d, fsw_q;
  logic [TOP_W-1:0] top_d, top_q;

  always_comb begin
    fsw_d = fsw_q;
    top_d = top_q;
    if (sw_load_i) begin
      top_d            = sw_data_i[TOP_LSB +: TOP_W];
      fsw_d            = sw_data_i & ~TOP_MASK;
      fsw_d[BUSY_BIT]  = sw_data_i[ES_BIT];
    end else if (push_i) begin
      top_d = top_q - 1'b1;
    end
    // a simultaneous error wins over the loaded summary bit
    if (num_err_i) begin
      fsw_d[ES_BIT]   = 1'b1;
      fsw_d[BUSY_BIT] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fsw_q <= '0;
      top_q <= '0;
    end else begin
      fsw_q <= fsw_d;
      top_q <= top_d;
    end
  end

  assign fsw_o = fsw_q;
  assign top_o = top_q;
endmodule

// File: rtl/fpe_irq_ctrl.sv
module fpe_irq_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic num_err_i,
  input  logic native_en_i,
  input  logic port_hit_i,
  input  logic es_clr_i,
  output logic irq_o,
  output logic ignne_o,
  output logic exc_o
);
  logic irq_q, ignne_q, exc_q;
  logic irq_d, ignne_d;
  logic err_set;

  assign err_set = num_err_i && !native_en_i && !ignne_q;

  always_comb begin
    irq_d   = irq_q;
    ignne_d = ignne_q;
    if (err_set)    irq_d = 1'b1;
    if (es_clr_i)   begin irq_d = 1'b0; ignne_d = 1'b0; end
    if (port_hit_i) begin irq_d = 1'b0; ignne_d = 1'b1; end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q   <= 1'b0;
      ignne_q <= 1'b0;
      exc_q   <= 1'b0;
    end else begin
      irq_q   <= irq_d;
      ignne_q <= ignne_d;
      exc_q   <= num_err_i && native_en_i;
    end
  end

  assign irq_o   = irq_q;
  assign ignne_o = ignne_q;
  assign exc_o   = exc_q;
endmodule

// File: rtl/fpe_err_handshake.sv
module fpe_err_handshake
  import fpe_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] ERR_PORT = 'h00F0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              num_err_i,
  input  logic              native_en_i,
  input  logic              io_wr_i,
  input  logic              io_rd_i,
  input  logic [ADDR_W-1:0] io_addr_i,
  input  logic              sw_load_i,
  input  logic [SW_W-1:0]   sw_data_i,
  input  logic              push_i,
  output logic              irq_o,
  output logic              ferr_o,
  output logic              ignne_o,
  output logic              exc_o,
  output logic [TOP_W-1:0]  top_o,
  output logic [SW_W-1:0]   fsw_o
);
  logic port_hit;
  logic es_clr;
  logic rd_unused;

  assign rd_unused = io_rd_i;  // reads carry no side effect
  assign es_clr    = sw_load_i && !sw_data_i[ES_BIT] && !num_err_i;

  fpe_port_decode #(.ADDR_W(ADDR_W), .ERR_PORT(ERR_PORT)) u_dec (
    .io_wr_i    (io_wr_i),
    .io_addr_i  (io_addr_i),
    .port_hit_o (port_hit)
  );

  fpe_status_reg u_sw (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .num_err_i (num_err_i),
    .sw_load_i (sw_load_i),
    .sw_data_i (sw_data_i),
    .push_i    (push_i),
    .fsw_o     (fsw_o),
    .top_o     (top_o)
  );

  fpe_irq_ctrl u_irq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .num_err_i   (num_err_i),
    .native_en_i (native_en_i),
    .port_hit_i  (port_hit),
    .es_clr_i    (es_clr),
    .irq_o       (irq_o),
    .ignne_o     (ignne_o),
    .exc_o       (exc_o)
  );

  // error output tracks the stored summary bit
  assign ferr_o = fsw_o[ES_BIT];
endmodule

// File: rtl/fpe_err_checker.sv
module fpe_err_checker
  import fpe_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter logic [ADDR_W-1:0] ERR_PORT = 'h00F0
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              num_err_i,
  input logic              native_en_i,
  input logic              io_wr_i,
  input logic [ADDR_W-1:0] io_addr_i,
  input logic              sw_load_i,
  input logic [SW_W-1:0]   sw_data_i,
  input logic              push_i,
  input logic              irq_o,
  input logic              ferr_o,
  input logic              ignne_o,
  input logic              exc_o,
  input logic [TOP_W-1:0]  top_o,
  input logic [SW_W-1:0]   fsw_o
);
  logic hit;
  assign hit = io_wr_i && (io_addr_i == ERR_PORT);

  AST_PORT_WR_DROPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> (!irq_o && ignne_o)); // R4
  AST_IGNORE_BLOCKS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ignne_o |-> !irq_o); // R6
  AST_IRQ_IMPLIES_FERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ferr_o); // R11
  AST_NATIVE_KEEPS_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (num_err_i && native_en_i && !hit && !sw_load_i) |=> $stable(irq_o)); // R3
  AST_EXC_FROM_NATIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(exc_o) |-> $past(num_err_i && native_en_i)); // R3
  AST_BUSY_MATCHES_ES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsw_o[BUSY_BIT] == fsw_o[ES_BIT]); // R9
  AST_TOP_FIELD_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fsw_o[TOP_LSB +: TOP_W] == '0); // R8
  AST_PUSH_DECREMENTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !sw_load_i) |=> top_o == $past(top_o) - 3'd1); // R10
  AST_LOAD_TAKES_TOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_load_i |=> top_o == $past(sw_data_i[TOP_LSB +: TOP_W])); // R8
endmodule

bind fpe_err_handshake fpe_err_checker #(.ADDR_W(ADDR_W), .ERR_PORT(ERR_PORT)) u_chk (.*);

// File: tb/tb_fpe_err_handshake.sv
module tb_fpe_err_handshake;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        num_err = 1'b0, native_en = 1'b0, io_wr = 1'b0, io_rd = 1'b0;
  logic [15:0] io_addr = '0;
  logic        sw_load = 1'b0, push = 1'b0;
  logic [15:0] sw_data = '0;
  logic        irq, ferr, ignne, exc;
  logic [2:0]  top;
  logic [15:0] fsw;
  int          n_chk = 0, n_bad = 0;

  always #4ns clk = ~clk;

  fpe_err_handshake dut (
    .clk_i(clk), .rst_ni(rst_n), .num_err_i(num_err), .native_en_i(native_en),
    .io_wr_i(io_wr), .io_rd_i(io_rd), .io_addr_i(io_addr), .sw_load_i(sw_load),
    .sw_data_i(sw_data), .push_i(push), .irq_o(irq), .ferr_o(ferr),
    .ignne_o(ignne), .exc_o(exc), .top_o(top), .fsw_o(fsw)
  );

  task automatic chk(input string req, input string what, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // release all strobes after one active edge
  task automatic step();
    @(negedge clk);
    num_err = 0; io_wr = 0; io_rd = 0; sw_load = 0; push = 0;
  endtask

  task automatic load(input logic [15:0] d);
    sw_load = 1; sw_data = d; step();
  endtask

  task automatic t_reset();
    chk("R1", "irq", 16'(irq), 0);   chk("R1", "ferr", 16'(ferr), 0);
    chk("R1", "ignne", 16'(ignne), 0); chk("R1", "exc", 16'(exc), 0);
    chk("R1", "top", 16'(top), 0);   chk("R1", "fsw", fsw, 0);
  endtask

  task automatic t_raise();
    native_en = 0; num_err = 1; step();
    chk("R2", "irq", 16'(irq), 1); chk("R2", "ferr", 16'(ferr), 1);
    chk("R2", "fsw", fsw, 16'h8080);
    repeat (5) step();
    chk("R11", "irq held", 16'(irq), 1);
  endtask

  task automatic t_no_effect();
    io_rd = 1; io_addr = 16'h00F0; step();
    chk("R5", "irq after read", 16'(irq), 1); chk("R5", "ignne after read", 16'(ignne), 0);
    io_wr = 1; io_addr = 16'h00F1; step();
    chk("R5", "irq after other wr", 16'(irq), 1); chk("R5", "ignne after other wr", 16'(ignne), 0);
    chk("R5", "ferr", 16'(ferr), 1);
  endtask

  task automatic t_port_write();
    io_wr = 1; io_addr = 16'h00F0; step();
    chk("R4", "irq", 16'(irq), 0); chk("R4", "ignne", 16'(ignne), 1);
    chk("R4", "ferr", 16'(ferr), 1);
  endtask

  task automatic t_err_ignored();
    num_err = 1; step();
    chk("R6", "irq", 16'(irq), 0); chk("R6", "ignne", 16'(ignne), 1);
  endtask

  task automatic t_es_clear();
    load(16'h0000);
    chk("R7", "ferr", 16'(ferr), 0); chk("R7", "ignne", 16'(ignne), 0);
    chk("R7", "irq", 16'(irq), 0);
    num_err = 1; step();
    chk("R2", "irq re-armed", 16'(irq), 1);
    load(16'h0001);
    chk("R11", "irq cleared by ES clear", 16'(irq), 0);
    chk("R7", "ferr", 16'(ferr), 0);
  endtask

  task automatic t_native();
    native_en = 1; num_err = 1; step();
    chk("R3", "exc", 16'(exc), 1); chk("R3", "irq", 16'(irq), 0);
    step();
    chk("R3", "exc one cycle", 16'(exc), 0);
    native_en = 0; load(16'h0000);
  endtask

  task automatic t_fields();
    load(16'h2A05);
    chk("R8", "top", 16'(top), 5); chk("R8", "fsw", fsw, 16'h0205);
    load(16'h4081);
    chk("R9", "fsw busy set", fsw, 16'hC081); chk("R8", "top", 16'(top), 0);
    load(16'h7FFF);
    chk("R8", "top 7", 16'(top), 7); chk("R9", "fsw", fsw, 16'hC7FF);
    load(16'h8000);
    chk("R9", "busy forced low", fsw, 16'h0000); chk("R7", "ferr", 16'(ferr), 0);
  endtask

  task automatic t_push();
    push = 1; step();
    chk("R10", "wrap 0->7", 16'(top), 7);
    push = 1; step();
    chk("R10", "7->6", 16'(top), 6);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_raise();
    t_no_effect();
    t_port_write();
    t_err_ignored();
    t_es_clear();
    t_native();
    t_fields();
    t_push();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule